// File: doc/BRIEF.md
# DDR2 Read/Write Latency Scheduler

This block sits in a memory controller next to a DDR2-style data path. For every read or write column command it works out the clock in which the burst data must be captured (read) or driven (write), and during those clocks it raises a data-valid window. The window carries the bank, the column, the index of the beat pair moving in that clock, and for writes the data-mask bits of both beats. The data path moves two beats per controller clock, so a burst of four beats fills two clocks and a burst of eight fills four.

Read latency is the programmed additive latency plus the programmed CAS latency. Write latency is always one clock less than read latency. Commands are sampled on the rising clock edge. A shift-register timeline holds several overlapping commands to any of the four banks at once. Commands issued one burst-length apart therefore produce windows with no gap between them. A command whose data window would land on clocks that an earlier command already holds is refused and flagged. A configuration write that carries an illegal setting is refused and sets a sticky error flag.

Top module: `ddr2_lat_sched`

## Requirements
- R1: After reset no window is open, `collision` and `cfgErr` are low, and the settings are CAS latency 3, additive latency 0 and burst length 4. A read issued with no configuration write therefore opens its window 3 clocks after it is sampled, for 2 clocks.
- R2: A read sampled at a rising edge raises `rdWin` exactly AL+CL rising edges later, counting that edge as the first.
- R3: A write raises `wrWin` one clock earlier than a read would, after AL+CL-1 edges.
- R4: `cfgBurst8`=1 selects 8 beats and a 4-clock window; `cfgBurst8`=0 selects 4 beats and a 2-clock window.
- R5: While a window is open, `winBank` and `winCol` carry the command's bank and column. `winBeat` gives the first beat index moved in that clock: 0, 2, 4, 6 in successive clocks. All payload outputs read zero when no window is open.
- R6: `cmdMask` bits [2b+1:2b] are the mask of beat b. During a write window, `winMask[1:0]` is the mask of beat `winBeat` and `winMask[3:2]` is the mask of beat `winBeat`+1. During a read window `winMask` is zero.
- R7: Commands of one type issued every BL/2 clocks produce back-to-back windows with no idle clock, each carrying its own bank.
- R8: A command whose window would overlap a scheduled window is dropped. `collision` is high for one clock, one edge after that command is sampled. The earlier window is unchanged.
- R9: A configuration write with CL below 3 or AL above 4 keeps all three previous settings and sets `cfgErr`. `cfgErr` stays set until reset, even across later legal writes.
- R10: A configuration write takes effect for commands sampled after the edge that samples it. A command sampled at that same edge uses the old settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| cfgWr | input | 1 | Load the three setting fields |
| cfgCl | input | 3 | CAS latency in clocks (3 to 7) |
| cfgAl | input | 3 | Additive latency in clocks (0 to 4) |
| cfgBurst8 | input | 1 | 1 = burst of 8, 0 = burst of 4 |
| cmdValid | input | 1 | Column command present |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdBank | input | 2 | Bank of the command |
| cmdCol | input | 10 | Column of the command |
| cmdMask | input | 16 | Per-beat write mask, 2 bits per beat |
| rdWin | output | 1 | Read data capture window |
| wrWin | output | 1 | Write data drive window |
| winBank | output | 2 | Bank of the open window |
| winCol | output | 10 | Column of the open window |
| winBeat | output | 3 | First beat index moved this clock |
| winMask | output | 4 | Mask of the two beats of this clock |
| collision | output | 1 | Command dropped for overlap |
| cfgErr | output | 1 | Sticky illegal-setting flag |

## Verification
A read's window appears L = AL+CL rising edges after the edge that samples it, and a write's after L-1. The window then stays open for BL/2 clocks. `collision` and `cfgErr` change one edge after the sampling edge. The bench drives inputs on falling edges and samples on the falling edge that follows the t-th rising edge. It logs every output per t and compares the whole window shape against one built from the requirements, so an off-by-one in any latency changes the shape. Overlap, turnaround, back-to-back and configuration-timing cases are directed runs with their expected t worked out the same way.

// File: rtl/ddr2_lat_pkg.sv
package ddr2_lat_pkg;
  localparam int BANK_W    = 2;
  localparam int COL_W     = 10;
  localparam int DM_W      = 2;
  localparam int MAX_AL    = 4;
  localparam int MIN_CL    = 3;
  localparam int MAX_CL    = 7;
  localparam int MAX_BEATS = 8;
  localparam int PAIRS_MAX = MAX_BEATS / 2;
  localparam int DEPTH     = MAX_AL + MAX_CL + PAIRS_MAX;
  localparam int IDX_W     = $clog2(DEPTH + 1);
  localparam int PAIR_W    = $clog2(PAIRS_MAX);
  localparam int MASK_W    = MAX_BEATS * DM_W;
  localparam int LAT_W     = $clog2(MAX_AL + MAX_CL + 1);

  // strobes from control to the slot timeline
  typedef struct packed {
    logic              load;
    logic              isWrite;
    logic [IDX_W-1:0]  start;
    logic [PAIR_W:0]   pairs;
  } sched_stb_t;
endpackage

// File: rtl/ddr2_lat_ctrl.sv
module ddr2_lat_ctrl
  import ddr2_lat_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [2:0]       cfgCl,
  input  logic [2:0]       cfgAl,
  input  logic             cfgBurst8,
  input  logic             cmdValid,
  input  logic             cmdWrite,
  input  logic [DEPTH-1:0] busy,
  output sched_stb_t       stb,
  output logic             collision,
  output logic             cfgErr
);
  logic [2:0] clReg;
  logic [2:0] alReg;
  logic       bl8Reg;
  logic       cfgLegal;

  assign cfgLegal = (cfgCl >= 3'(MIN_CL)) && (cfgAl <= 3'(MAX_AL));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clReg  <= 3'(MIN_CL);
      alReg  <= '0;
      bl8Reg <= 1'b0;
      cfgErr <= 1'b0;
    end else if (cfgWr) begin
      if (cfgLegal) begin
        clReg  <= cfgCl;
        alReg  <= cfgAl;
        bl8Reg <= cfgBurst8;
      end else begin
        cfgErr <= 1'b1;
      end
    end
  end

  logic [LAT_W-1:0]  readLat;
  logic [LAT_W-1:0]  cmdLat;
  logic [IDX_W-1:0]  startIdx;
  logic [PAIR_W:0]   pairCnt;
  logic [DEPTH-1:0]  winVec;
  logic [DEPTH-1:0]  busyNext;
  logic              clash;

  assign readLat  = LAT_W'(alReg) + LAT_W'(clReg);
  assign cmdLat   = cmdWrite ? readLat - LAT_W'(1) : readLat;
  // a slot reaching index 0 after L-1 more shifts is visible L edges after sampling
  assign startIdx = IDX_W'(cmdLat - LAT_W'(1));
  assign pairCnt  = bl8Reg ? (PAIR_W+1)'(PAIRS_MAX) : (PAIR_W+1)'(PAIRS_MAX / 2);

  for (genvar i = 0; i < DEPTH; i++) begin : g_win
    assign winVec[i] = ((IDX_W+1)'(i) >= {1'b0, startIdx}) &&
                       ((IDX_W+1)'(i) <  {1'b0, startIdx} + (IDX_W+1)'(pairCnt));
  end

  // image of the timeline after this edge's shift
  assign busyNext = {1'b0, busy[DEPTH-1:1]};
  assign clash    = |(winVec & busyNext);

  always_comb begin
    stb.load    = cmdValid && !clash;
    stb.isWrite = cmdWrite;
    stb.start   = startIdx;
    stb.pairs   = pairCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) collision <= 1'b0;
    else       collision <= cmdValid && clash;
  end
endmodule

// File: rtl/ddr2_lat_dpath.sv
module ddr2_lat_dpath
  import ddr2_lat_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  sched_stb_t          stb,
  input  logic [BANK_W-1:0]   cmdBank,
  input  logic [COL_W-1:0]    cmdCol,
  input  logic [MASK_W-1:0]   cmdMask,
  output logic [DEPTH-1:0]    busy,
  output logic                rdWin,
  output logic                wrWin,
  output logic [BANK_W-1:0]   winBank,
  output logic [COL_W-1:0]    winCol,
  output logic [PAIR_W:0]     winBeat,
  output logic [2*DM_W-1:0]   winMask
);
  typedef struct packed {
    logic                valid;
    logic                isWr;
    logic [BANK_W-1:0]   bank;
    logic [COL_W-1:0]    col;
    logic [PAIR_W-1:0]   pair;
    logic [2*DM_W-1:0]   mask;
  } slot_t;

  slot_t slots [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [IDX_W-1:0] off;
    logic             hit;
    slot_t            fresh;
    slot_t            nxt;

    assign off = IDX_W'(i) - stb.start;
    assign hit = stb.load &&
                 ((IDX_W+1)'(i) >= {1'b0, stb.start}) &&
                 ((IDX_W+1)'(i) <  {1'b0, stb.start} + (IDX_W+1)'(stb.pairs));

    always_comb begin
      fresh.valid = 1'b1;
      fresh.isWr  = stb.isWrite;
      fresh.bank  = cmdBank;
      fresh.col   = cmdCol;
      fresh.pair  = off[PAIR_W-1:0];
      fresh.mask  = cmdMask[off[PAIR_W-1:0] * 2 * DM_W +: 2 * DM_W];
    end

    if (i == DEPTH - 1) begin : g_last
      assign nxt = '0;
    end else begin : g_mid
      assign nxt = slots[i+1];
    end

    always_ff @(posedge clk) begin
      if (!rstN)    slots[i] <= '0;
      else if (hit) slots[i] <= fresh;
      else          slots[i] <= nxt;
    end

    assign busy[i] = slots[i].valid;
  end

  slot_t head;
  assign head    = slots[0];
  assign rdWin   = head.valid && !head.isWr;
  assign wrWin   = head.valid && head.isWr;
  assign winBank = head.valid ? head.bank : '0;
  assign winCol  = head.valid ? head.col : '0;
  assign winBeat = head.valid ? {head.pair, 1'b0} : '0;
  assign winMask = wrWin ? head.mask : '0;
endmodule

// File: rtl/ddr2_lat_sched.sv
module ddr2_lat_sched
  import ddr2_lat_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWr,
  input  logic [2:0]          cfgCl,
  input  logic [2:0]          cfgAl,
  input  logic                cfgBurst8,
  input  logic                cmdValid,
  input  logic                cmdWrite,
  input  logic [BANK_W-1:0]   cmdBank,
  input  logic [COL_W-1:0]    cmdCol,
  input  logic [MASK_W-1:0]   cmdMask,
  output logic                rdWin,
  output logic                wrWin,
  output logic [BANK_W-1:0]   winBank,
  output logic [COL_W-1:0]    winCol,
  output logic [PAIR_W:0]     winBeat,
  output logic [2*DM_W-1:0]   winMask,
  output logic                collision,
  output logic                cfgErr
);
  sched_stb_t       stb;
  logic [DEPTH-1:0] busy;

  ddr2_lat_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgCl(cfgCl), .cfgAl(cfgAl),
    .cfgBurst8(cfgBurst8), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .busy(busy), .stb(stb), .collision(collision), .cfgErr(cfgErr)
  );

  ddr2_lat_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdBank(cmdBank), .cmdCol(cmdCol),
    .cmdMask(cmdMask), .busy(busy), .rdWin(rdWin), .wrWin(wrWin),
    .winBank(winBank), .winCol(winCol), .winBeat(winBeat), .winMask(winMask)
  );
endmodule

// File: rtl/ddr2_lat_sched_chk.sv
module ddr2_lat_sched_chk
  import ddr2_lat_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                cmdValid,
  input logic                rdWin,
  input logic                wrWin,
  input logic [BANK_W-1:0]   winBank,
  input logic [COL_W-1:0]    winCol,
  input logic [PAIR_W:0]     winBeat,
  input logic [2*DM_W-1:0]   winMask,
  input logic                collision,
  input logic                cfgErr
);
  // R9
  cfg_err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);

  // R8
  collision_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    collision |-> $past(cmdValid));

  // R8
  single_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdWin && wrWin));

  // R5
  beat_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((rdWin || wrWin) && winBeat != '0) |->
      ($past(rdWin) == rdWin && $past(wrWin) == wrWin &&
       $past(winBeat) == winBeat - (PAIR_W+1)'(2)));

  // R6
  read_mask_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdWin |-> winMask == '0);

  // R5
  idle_payload_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdWin || wrWin) |-> (winBeat == '0 && winBank == '0 && winCol == '0));
endmodule

bind ddr2_lat_sched ddr2_lat_sched_chk u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .rdWin(rdWin), .wrWin(wrWin),
  .winBank(winBank), .winCol(winCol), .winBeat(winBeat), .winMask(winMask),
  .collision(collision), .cfgErr(cfgErr)
);

// File: tb/ddr2_lat_sched_bench.sv
module ddr2_lat_sched_bench;
  import ddr2_lat_pkg::*;

  logic clk = 1'b0;
  always #4ns clk = ~clk;

  logic        rstN, cfgWr, cfgBurst8, cmdValid, cmdWrite;
  logic [2:0]  cfgCl, cfgAl;
  logic [1:0]  cmdBank;
  logic [9:0]  cmdCol;
  logic [15:0] cmdMask;
  logic        rdWin, wrWin, collision, cfgErr;
  logic [1:0]  winBank;
  logic [9:0]  winCol;
  logic [2:0]  winBeat;
  logic [3:0]  winMask;

  ddr2_lat_sched u_ddr2_lat_sched (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgCl(cfgCl), .cfgAl(cfgAl),
    .cfgBurst8(cfgBurst8), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdBank(cmdBank), .cmdCol(cmdCol), .cmdMask(cmdMask),
    .rdWin(rdWin), .wrWin(wrWin), .winBank(winBank), .winCol(winCol),
    .winBeat(winBeat), .winMask(winMask), .collision(collision), .cfgErr(cfgErr)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  logic [31:0] rdS, wrS, colS;
  logic [1:0]  bankLog [32];
  logic [9:0]  colLog  [32];
  logic [2:0]  beatLog [32];
  logic [3:0]  maskLog [32];

  // cl[35:33] al[32:30] bl8[29] wr[28] bank[27:26] col[25:16] mask[15:0]
  localparam logic [35:0] VECS [6] = '{
    {3'd3, 3'd0, 1'b0, 1'b0, 2'd1, 10'h010, 16'h0000},
    {3'd3, 3'd0, 1'b0, 1'b1, 2'd2, 10'h024, 16'h00B4},
    {3'd5, 3'd2, 1'b1, 1'b0, 2'd3, 10'h3F8, 16'hFFFF},
    {3'd7, 3'd4, 1'b1, 1'b1, 2'd0, 10'h100, 16'hC639},
    {3'd4, 3'd1, 1'b1, 1'b1, 2'd1, 10'h2A0, 16'h5A0F},
    {3'd6, 3'd3, 1'b0, 1'b0, 2'd2, 10'h077, 16'h1234}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] win(input int s, input int n);
    logic [31:0] r = '0;
    for (int t = s; t < s + n; t++) r[t] = 1'b1;
    return r;
  endfunction

  task automatic setCfg(input logic [2:0] cl, input logic [2:0] al, input logic b8);
    cfgWr = 1'b1; cfgCl = cl; cfgAl = al; cfgBurst8 = b8;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  // drive a command at the current falling edge, optionally a second at t == at2
  task automatic run(input logic w1, input logic [1:0] b1, input logic [9:0] c1,
                     input logic [15:0] m1, input int at2, input logic w2,
                     input logic [1:0] b2);
    rdS = '0; wrS = '0; colS = '0;
    cmdValid = 1'b1; cmdWrite = w1; cmdBank = b1; cmdCol = c1; cmdMask = m1;
    for (int t = 1; t < 25; t++) begin
      @(negedge clk);
      rdS[t] = rdWin; wrS[t] = wrWin; colS[t] = collision;
      bankLog[t] = winBank; colLog[t] = winCol; beatLog[t] = winBeat; maskLog[t] = winMask;
      if (t == 1) begin cmdValid = 1'b0; cfgWr = 1'b0; end
      if (at2 != 0 && t == at2) begin
        cmdValid = 1'b1; cmdWrite = w2; cmdBank = b2; cmdCol = 10'h055; cmdMask = '0;
      end
      if (at2 != 0 && t == at2 + 1) cmdValid = 1'b0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cfgWr = 1'b0; cfgCl = 3'd0; cfgAl = 3'd0; cfgBurst8 = 1'b0;
    cmdValid = 1'b0; cmdWrite = 1'b0; cmdBank = '0; cmdCol = '0; cmdMask = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 idle outputs", {rdWin, wrWin, collision, cfgErr, winBeat, winMask}, '0);
    run(1'b0, 2'd1, 10'h005, '0, 0, 1'b0, 2'd0);
    chk("R1 default read window", rdS, win(3, 2));
    chk("R1 no write window", wrS, '0);

    // vector table: R2 R3 R4 R5 R6
    for (int v = 0; v < 6; v++) begin
      logic [35:0] e;
      int lat, n;
      e = VECS[v];
      setCfg(e[35:33], e[32:30], e[29]);
      lat = int'(e[35:33]) + int'(e[32:30]) - (e[28] ? 1 : 0);
      n = e[29] ? 4 : 2;
      run(e[28], e[27:26], e[25:16], e[15:0], 0, 1'b0, 2'd0);
      chk(e[28] ? "R3 R4 write window" : "R2 R4 read window",
          e[28] ? wrS : rdS, win(lat, n));
      chk("R2 R3 other window idle", e[28] ? rdS : wrS, '0);
      for (int t = lat; t < lat + n; t++) begin
        logic [3:0] em;
        em = e[28] ? e[(t - lat) * 4 +: 4] : 4'h0;
        chk("R5 R6 window payload", {bankLog[t], colLog[t], beatLog[t], maskLog[t]},
            {e[27:26], e[25:16], 3'((t - lat) * 2), em});
      end
    end

    // R7 back-to-back reads, BL4 CL3 AL0
    setCfg(3'd3, 3'd0, 1'b0);
    run(1'b0, 2'd1, 10'h011, '0, 2, 1'b0, 2'd2);
    chk("R7 gapless read windows", rdS, win(3, 4));
    chk("R7 bank per burst", {bankLog[4], bankLog[5], beatLog[5], beatLog[6]},
        {2'd1, 2'd2, 3'd0, 3'd2});
    chk("R7 no collision", colS, '0);

    // R8 read then overlapping write
    run(1'b0, 2'd1, 10'h012, '0, 2, 1'b1, 2'd3);
    chk("R8 collision pulse", colS, win(3, 1));
    chk("R8 earlier read kept", rdS, win(3, 2));
    chk("R8 dropped write", wrS, '0);
    // R3 turnaround one clock later fits
    run(1'b0, 2'd1, 10'h013, '0, 3, 1'b1, 2'd3);
    chk("R3 write after read", wrS, win(5, 2));
    chk("R8 no collision on gap", colS, '0);

    // R10 config write at the same edge as a command
    setCfg(3'd4, 3'd0, 1'b0);
    cfgWr = 1'b1; cfgCl = 3'd6; cfgAl = 3'd0; cfgBurst8 = 1'b0;
    run(1'b0, 2'd0, 10'h020, '0, 0, 1'b0, 2'd0);
    chk("R10 same-edge command uses old CL", rdS, win(4, 2));
    run(1'b0, 2'd0, 10'h021, '0, 0, 1'b0, 2'd0);
    chk("R10 next command uses new CL", rdS, win(6, 2));

    // R9 illegal settings
    setCfg(3'd3, 3'd0, 1'b0);
    chk("R9 flag clear on legal", {31'd0, cfgErr}, 32'd0);
    setCfg(3'd2, 3'd0, 1'b1);
    chk("R9 flag set on CL 2", {31'd0, cfgErr}, 32'd1);
    run(1'b0, 2'd2, 10'h030, '0, 0, 1'b0, 2'd0);
    chk("R9 settings kept", rdS, win(3, 2));
    setCfg(3'd3, 3'd5, 1'b0);
    run(1'b0, 2'd2, 10'h031, '0, 0, 1'b0, 2'd0);
    chk("R9 AL 5 refused", rdS, win(3, 2));
    setCfg(3'd4, 3'd0, 1'b0);
    chk("R9 flag sticky", {31'd0, cfgErr}, 32'd1);
    run(1'b0, 2'd2, 10'h032, '0, 0, 1'b0, 2'd0);
    chk("R9 later legal write applies", rdS, win(4, 2));

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule